// File: doc/BRIEF.md
# SPI Slave Memory Bridge

This block is the device-side end of a serial memory link. It works as an SPI slave in mode 0: it samples MOSI on rising SCLK edges and changes MISO on falling edges. Each transaction is framed by chip select. The block decodes a one-byte command and a 32-bit address, then carries out reads or writes on a synchronous memory port inside the device. That port is 8 bytes wide, takes byte enables and has a one-cycle read latency.

Data moves in words of 2, 4 or 8 bytes, with the size chosen by the command. Words go over the wire most significant byte first and are stored little-endian, so the first byte of a word lands at the highest address that word covers. The address advances by one word size after every word. This lets a single frame stream a run of consecutive words.

Two kinds of command are limited. A 16-bit command is honoured only inside a fixed address window. An 8-byte burst write stops storing words once its byte limit is reached. The SPI pins are brought into the system clock domain through synchronizers. SCLK must therefore stay at least 6 system clocks high and 6 low.

Top module: `spi_mem_bridge`

## Requirements
- R1: The first byte after chip select falls is the command. Values 0 and 1 select 2-byte words, 2 and 3 select 4-byte words, and 4 and 5 select 8-byte words. Bit 0 set means write and bit 0 clear means read. Any value of 6 or above causes no memory access.
- R2: The next four bytes give the start address, most significant byte first. Address bits below the word size are ignored. `mem_addr` is always a multiple of 8, and `mem_be` marks the word's bytes at lane `addr[2:0]` with the low bits cleared.
- R3: For a write, the first wire byte of each word is stored at the word's highest byte address and the last wire byte at its lowest.
- R4: A 16-bit command with a start address outside [0x18020000, 0x18021000) makes no memory access. It raises `range_err` from the end of the header until chip select next falls.
- R5: A read has 4 dummy bytes after the address, during which MISO is 0. From the first bit of byte 9 onward, MISO sends each word most significant byte first, in the same order a write takes.
- R6: Bits that do not complete a word are never written. This covers the one trailing dummy byte of a write and a frame cut short by chip select.
- R7: After every word the address advances by the word size, so successive words of a frame use consecutive memory locations.
- R8: An 8-byte write stores at most 240 bytes (30 words). Words after that limit are dropped.
- R9: After reset, `mem_req` is 0, `spi_miso` is 0 and `range_err` is 0.
- R10: MOSI is sampled on rising SCLK edges and MISO changes only after falling edges. MISO is 0 while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| mem_req | output | 1 | Memory access strobe, one cycle per word |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 32 | Byte address, multiple of 8 |
| mem_be | output | 8 | Byte enables, one per byte lane |
| mem_wdata | output | 64 | Write data placed on its lanes |
| mem_rdata | input | 64 | Read data, valid the cycle after the request |
| range_err | output | 1 | 16-bit command outside the allowed window |

## Verification
The bench builds the block with its default parameters: window [0x18020000, 0x18021000), a 240-byte burst limit and two synchronizer stages. With the 240-byte limit, a 248-byte burst reaches the point where words start being dropped. The default window puts both window edges and an address just below it within reach of 16-bit frames. The memory model decodes only the low 12 address bits, so window addresses and ordinary addresses share one small byte array.

// File: rtl/spi_mb_pkg.sv
`timescale 1ns/1ps
package spi_mb_pkg;
  localparam int HDR_BITS   = 40;
  localparam int DUMMY_BITS = 32;

  // bytes per data word for a command byte, 0 for an unknown command
  function automatic logic [3:0] op_bytes(input logic [7:0] op);
    if (op < 8'd2)      return 4'd2;
    else if (op < 8'd4) return 4'd4;
    else if (op < 8'd6) return 4'd8;
    else                return 4'd0;
  endfunction

  // byte lane of a word inside the 8-byte memory beat
  function automatic logic [2:0] lane_of(input logic [2:0] a, input logic [3:0] nb);
    return a & ~(nb[2:0] - 3'd1);
  endfunction

  function automatic logic [63:0] word_mask(input logic [3:0] nb);
    if (nb == 4'd8) return '1;
    return (64'd1 << {nb, 3'b000}) - 64'd1;
  endfunction

  function automatic logic [7:0] byte_en(input logic [3:0] nb, input logic [2:0] lane);
    logic [15:0] m;
    m = ((16'd1 << nb) - 16'd1) << lane;
    return m[7:0];
  endfunction

  function automatic logic in_window(input logic [31:0] a, input logic [31:0] lo,
                                     input logic [31:0] hi);
    return (a >= lo) && (a < hi);
  endfunction
endpackage

// File: rtl/spi_mb_sync.sv
`timescale 1ns/1ps
module spi_mb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_fall,
  output logic cs_act,
  output logic mosi_s
);
  // bit 2 sclk, bit 1 cs_n, bit 0 mosi; last entry is the edge-detect history
  logic [STAGES:0][2:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= {(STAGES + 1){3'b010}};
    end else begin
      pipe[0] <= {sclk, cs_n, mosi};
      for (int i = 1; i <= STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign cs_act    = ~pipe[STAGES-1][1];
  assign cs_fall   = ~pipe[STAGES-1][1] &  pipe[STAGES][1];
  assign sclk_rise =  pipe[STAGES-1][2] & ~pipe[STAGES][2];
  assign sclk_fall = ~pipe[STAGES-1][2] &  pipe[STAGES][2];
  assign mosi_s    =  pipe[STAGES-1][0];
endmodule

// File: rtl/spi_mb_frame.sv
`timescale 1ns/1ps
module spi_mb_frame #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_fall,
  input  logic             cs_act,
  input  logic             sclk_rise,
  input  logic             mosi_s,
  output logic [CNT_W-1:0] bit_cnt,
  output logic [63:0]      rx_sh,
  output logic             bit_evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
      bit_evt <= 1'b0;
    end else begin
      bit_evt <= cs_act && sclk_rise && !cs_fall;
      if (cs_fall) begin
        bit_cnt <= '0;
      end else if (cs_act && sclk_rise) begin
        rx_sh <= {rx_sh[62:0], mosi_s};
        if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_mb_tx.sv
`timescale 1ns/1ps
module spi_mb_tx import spi_mb_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_act,
  input  logic        cap_en,
  input  logic [2:0]  cap_lane,
  input  logic [3:0]  nb,
  input  logic [63:0] rdata,
  input  logic        load,
  input  logic        shift,
  output logic        miso
);
  logic [63:0] buf_q, sh_q, aligned;

  // prefetched word moved to the top so its most significant bit leads
  assign aligned = buf_q << (7'd64 - {nb, 3'b000});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      sh_q  <= '0;
      miso  <= 1'b0;
    end else begin
      if (cap_en) buf_q <= (rdata >> {cap_lane, 3'b000}) & word_mask(nb);
      if (!cs_act) begin
        miso <= 1'b0;
      end else if (load) begin
        miso <= aligned[63];
        sh_q <= aligned << 1;
      end else if (shift) begin
        miso <= sh_q[63];
        sh_q <= sh_q << 1;
      end
    end
  end
endmodule

// File: rtl/spi_mem_bridge.sv
`timescale 1ns/1ps
module spi_mem_bridge import spi_mb_pkg::*; #(
  parameter logic [31:0] WIN_LO          = 32'h1802_0000,
  parameter logic [31:0] WIN_HI          = 32'h1802_1000,
  parameter int          BURST_MAX_BYTES = 240,
  parameter int          SYNC_STAGES     = 2,
  parameter int          CNT_W           = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_sclk,
  input  logic        spi_cs_n,
  input  logic        spi_mosi,
  output logic        spi_miso,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [7:0]  mem_be,
  output logic [63:0] mem_wdata,
  input  logic [63:0] mem_rdata,
  output logic        range_err
);
  localparam int WORD_CAP = BURST_MAX_BYTES / 8;
  localparam int WCNT_W   = $clog2(WORD_CAP + 2);
  localparam logic [CNT_W-1:0] HDR_END = CNT_W'(HDR_BITS);
  localparam logic [CNT_W-1:0] RD_BEG  = CNT_W'(HDR_BITS + DUMMY_BITS);

  logic sclk_rise, sclk_fall, cs_fall, cs_act, mosi_s, bit_evt;
  logic [CNT_W-1:0] bit_cnt;
  logic [63:0]      rx_sh;

  spi_mb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_fall(cs_fall),
    .cs_act(cs_act), .mosi_s(mosi_s));

  spi_mb_frame #(.CNT_W(CNT_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_act(cs_act),
    .sclk_rise(sclk_rise), .mosi_s(mosi_s), .bit_cnt(bit_cnt), .rx_sh(rx_sh),
    .bit_evt(bit_evt));

  // command state
  logic [7:0]        op_q;
  logic [31:0]       addr_q;
  logic [3:0]        nb_q;
  logic              is_rd_q, active_q, err_q, rd_pend_q;
  logic [2:0]        lane_pf_q;
  logic [WCNT_W-1:0] words_q;

  // named events
  logic        hdr_op_evt, hdr_done, op_valid, hdr_win_ok, hdr_accept;
  logic        wr_fire, rd_load, rd_shift, pf_fire, at_cap;
  logic [3:0]  hdr_nb, cur_nb;
  logic [31:0] hdr_addr, cur_addr;
  logic [2:0]  cur_lane;
  logic [6:0]  wmask;
  logic [CNT_W-1:0] wr_bits, rd_bits;

  assign hdr_op_evt = bit_evt && (bit_cnt == CNT_W'(8));
  assign hdr_done   = bit_evt && (bit_cnt == HDR_END);
  assign hdr_addr   = rx_sh[31:0];
  assign hdr_nb     = op_bytes(op_q);
  assign op_valid   = (hdr_nb != 4'd0);
  assign hdr_win_ok = (hdr_nb != 4'd2) || in_window(hdr_addr, WIN_LO, WIN_HI);
  assign hdr_accept = hdr_done && op_valid && hdr_win_ok;

  assign wmask   = {nb_q, 3'b000} - 7'd1;
  assign wr_bits = bit_cnt - HDR_END;
  assign rd_bits = bit_cnt - RD_BEG;
  assign at_cap  = (nb_q == 4'd8) && (words_q >= WCNT_W'(WORD_CAP));

  assign wr_fire  = bit_evt && active_q && !is_rd_q && (bit_cnt > HDR_END)
                    && ((wr_bits[6:0] & wmask) == 7'd0) && !at_cap;
  assign rd_load  = sclk_fall && cs_act && active_q && is_rd_q && (bit_cnt >= RD_BEG)
                    && ((rd_bits[6:0] & wmask) == 7'd0);
  assign rd_shift = sclk_fall && cs_act && active_q && is_rd_q && (bit_cnt >= RD_BEG)
                    && ((rd_bits[6:0] & wmask) != 7'd0);
  assign pf_fire  = (hdr_accept && !op_q[0]) || rd_load;

  assign cur_addr = hdr_done ? hdr_addr : addr_q;
  assign cur_nb   = hdr_done ? hdr_nb   : nb_q;
  assign cur_lane = lane_of(cur_addr[2:0], cur_nb);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
      rd_pend_q <= 1'b0;
      lane_pf_q <= '0;
      op_q      <= '0;
      addr_q    <= '0;
      nb_q      <= '0;
      is_rd_q   <= 1'b0;
      active_q  <= 1'b0;
      err_q     <= 1'b0;
      words_q   <= '0;
    end else begin
      mem_req   <= wr_fire || pf_fire;
      mem_we    <= wr_fire;
      rd_pend_q <= mem_req && !mem_we;
      if (wr_fire || pf_fire) begin
        mem_addr  <= {cur_addr[31:3], 3'b000};
        mem_be    <= byte_en(cur_nb, cur_lane);
        mem_wdata <= (rx_sh & word_mask(cur_nb)) << {cur_lane, 3'b000};
      end
      if (pf_fire) lane_pf_q <= cur_lane;

      if (cs_fall) begin
        err_q    <= 1'b0;
        active_q <= 1'b0;
        words_q  <= '0;
      end else if (!cs_act) begin
        active_q <= 1'b0;
      end else begin
        if (hdr_op_evt) op_q <= rx_sh[7:0];
        if (hdr_done) begin
          nb_q     <= hdr_nb;
          is_rd_q  <= !op_q[0];
          active_q <= hdr_accept;
          err_q    <= op_valid && !hdr_win_ok;
          addr_q   <= hdr_addr + ((hdr_accept && !op_q[0]) ? {28'd0, hdr_nb} : 32'd0);
        end else if (wr_fire || rd_load) begin
          addr_q <= addr_q + {28'd0, nb_q};
        end
        if (wr_fire && nb_q == 4'd8) words_q <= words_q + 1'b1;
      end
    end
  end

  spi_mb_tx u_tx (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .cap_en(rd_pend_q),
    .cap_lane(lane_pf_q), .nb(nb_q), .rdata(mem_rdata), .load(rd_load),
    .shift(rd_shift), .miso(spi_miso));

  assign range_err = err_q;
endmodule

// File: rtl/spi_mb_chk.sv
`timescale 1ns/1ps
module spi_mb_chk #(
  parameter int CNT_W    = 12,
  parameter int WORD_CAP = 30,
  parameter int WCNT_W   = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_act,
  input logic             cs_fall,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             mem_req,
  input logic             mem_we,
  input logic [7:0]       mem_be,
  input logic [31:0]      mem_addr,
  input logic [3:0]       nb_q,
  input logic [WCNT_W-1:0] words_q,
  input logic             range_err,
  input logic             spi_miso
);
  // R6: no write before a full first word has arrived
  a_r6_full_word_only: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> bit_cnt >= CNT_W'(56));
  // R2: byte enables cover exactly one word, on an 8-byte aligned beat
  a_r2_be_width: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ($countones(mem_be) == int'(nb_q)) && (mem_addr[2:0] == 3'd0));
  // R4: flag holds until the next frame starts
  a_r4_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    range_err && !cs_fall |=> range_err);
  // R4: a rejected command never reaches memory
  a_r4_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    range_err |-> !mem_req);
  // R10: MISO quiet outside a frame
  a_r10_miso_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !spi_miso);
  // R8: burst writes stay within the word limit
  a_r8_cap: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && nb_q == 4'd8 |-> words_q <= WCNT_W'(WORD_CAP));
endmodule

bind spi_mem_bridge spi_mb_chk #(.CNT_W(CNT_W), .WORD_CAP(WORD_CAP), .WCNT_W(WCNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .cs_fall(cs_fall), .bit_cnt(bit_cnt),
  .mem_req(mem_req), .mem_we(mem_we), .mem_be(mem_be), .mem_addr(mem_addr),
  .nb_q(nb_q), .words_q(words_q), .range_err(range_err), .spi_miso(spi_miso));

// File: tb/spi_mem_bridge_tb.sv
`timescale 1ns/1ps
module spi_mem_bridge_tb;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, mem_req, mem_we, range_err;
  logic [31:0] mem_addr;
  logic [7:0]  mem_be;
  logic [63:0] mem_wdata, mem_rdata;

  always #2 clk = ~clk;

  spi_mem_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .range_err(range_err));

  // memory model: 4 KiB, low 12 address bits decoded
  logic [7:0] mem [0:4095];
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4096; i++) mem[i] <= 8'(i * 7 + 3);
      mem_rdata <= '0;
    end else if (mem_req) begin
      if (mem_we) begin
        for (int b = 0; b < 8; b++)
          if (mem_be[b]) mem[{mem_addr[11:3], 3'(b)}] <= mem_wdata[b*8 +: 8];
      end else begin
        for (int b = 0; b < 8; b++) mem_rdata[b*8 +: 8] <= mem[{mem_addr[11:3], 3'(b)}];
      end
    end
  end

  function automatic logic [7:0] init_val(input int i);
    return 8'(i * 7 + 3);
  endfunction

  int total = 0, fails = 0;
  logic [7:0] tx_b [0:299];
  logic [7:0] rx_b [0:299];

  task automatic chk(input logic ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_hdr(input logic [7:0] op, input logic [31:0] a);
    tx_b[0] = op;
    tx_b[1] = a[31:24];
    tx_b[2] = a[23:16];
    tx_b[3] = a[15:8];
    tx_b[4] = a[7:0];
    for (int i = 5; i < 300; i++) tx_b[i] = 8'h00;
  endtask

  // mode 0 frame of nbits bits; MISO sampled just before each rising edge
  task automatic frame(input int nbits);
    for (int i = 0; i < 300; i++) rx_b[i] = 8'h00;
    cyc(1);
    cs_n = 1'b0;
    cyc(HALF);
    for (int i = 0; i < nbits; i++) begin
      mosi = tx_b[i/8][7 - (i % 8)];
      cyc(HALF);
      rx_b[i/8][7 - (i % 8)] = miso;
      sclk = 1'b1;
      cyc(HALF);
      sclk = 1'b0;
    end
    cyc(HALF);
    cs_n = 1'b1;
    cyc(16);
  endtask

  task automatic t_reset;
    chk(!mem_req, "R9 mem_req", 64'(mem_req), 0);
    chk(!miso, "R9 miso", 64'(miso), 0);
    chk(!range_err, "R9 range_err", 64'(range_err), 0);
  endtask

  task automatic t_wr32;
    set_hdr(8'h03, 32'h0000_0104);
    tx_b[5] = 8'hAA; tx_b[6] = 8'hBB; tx_b[7] = 8'hCC; tx_b[8] = 8'hDD; tx_b[9] = 8'hEE;
    frame(80);
    chk({mem[12'h107], mem[12'h106], mem[12'h105], mem[12'h104]} == 32'hAABBCCDD,
        "R3 wr32 byte order",
        {mem[12'h107], mem[12'h106], mem[12'h105], mem[12'h104]}, 64'hAABBCCDD);
    chk(mem[12'h108] == init_val(12'h108), "R6 trailing dummy not stored",
        mem[12'h108], init_val(12'h108));
  endtask

  task automatic t_rd32;
    set_hdr(8'h02, 32'h0000_0104);
    frame(13 * 8);
    chk(rx_b[8] == 8'h00, "R5 dummy bytes zero", rx_b[8], 0);
    chk({rx_b[9], rx_b[10], rx_b[11], rx_b[12]} == 32'hAABBCCDD, "R5 R10 rd32 data",
        {rx_b[9], rx_b[10], rx_b[11], rx_b[12]}, 64'hAABBCCDD);
  endtask

  task automatic t_align;
    set_hdr(8'h03, 32'h0000_0106);
    tx_b[5] = 8'h01; tx_b[6] = 8'h02; tx_b[7] = 8'h03; tx_b[8] = 8'h04;
    frame(80);
    chk({mem[12'h107], mem[12'h106], mem[12'h105], mem[12'h104]} == 32'h01020304,
        "R2 low address bits ignored",
        {mem[12'h107], mem[12'h106], mem[12'h105], mem[12'h104]}, 64'h01020304);
  endtask

  task automatic t_burst;
    logic ok;
    set_hdr(8'h05, 32'h0000_0200);
    for (int k = 0; k < 16; k++) tx_b[5 + k] = 8'(8'h10 + k);
    tx_b[21] = 8'hEE;
    frame(22 * 8);
    ok = 1'b1;
    for (int i = 0; i < 16; i++) begin
      int src = (i / 8) * 8 + 7 - (i % 8);
      if (mem[12'h200 + i] != 8'(8'h10 + src)) ok = 1'b0;
    end
    chk(ok, "R7 R3 burst write two words", 64'(ok), 1);
    chk(mem[12'h210] == init_val(12'h210), "R6 burst dummy not stored",
        mem[12'h210], init_val(12'h210));
    set_hdr(8'h04, 32'h0000_0200);
    frame(25 * 8);
    ok = 1'b1;
    for (int k = 0; k < 16; k++) if (rx_b[9 + k] != 8'(8'h10 + k)) ok = 1'b0;
    chk(ok, "R7 R5 burst read two words", {rx_b[17], rx_b[9]}, 64'h1810);
  endtask

  task automatic t_win16;
    set_hdr(8'h01, 32'h1802_0FFE);
    tx_b[5] = 8'h12; tx_b[6] = 8'h34; tx_b[7] = 8'hEE;
    frame(64);
    chk({mem[12'hFFF], mem[12'hFFE]} == 16'h1234, "R4 in-window 16-bit write",
        {mem[12'hFFF], mem[12'hFFE]}, 64'h1234);
    chk(!range_err, "R4 no flag in window", 64'(range_err), 0);
    set_hdr(8'h00, 32'h1802_0FFE);
    frame(11 * 8);
    chk({rx_b[9], rx_b[10]} == 16'h1234, "R5 16-bit read", {rx_b[9], rx_b[10]}, 64'h1234);
  endtask

  task automatic t_outwin;
    set_hdr(8'h01, 32'h1802_1000);
    tx_b[5] = 8'h56; tx_b[6] = 8'h78;
    frame(56);
    chk({mem[12'h001], mem[12'h000]} == {init_val(1), init_val(0)},
        "R4 upper edge ignored", {mem[12'h001], mem[12'h000]}, {init_val(1), init_val(0)});
    chk(range_err, "R4 flag at upper edge", 64'(range_err), 1);
    set_hdr(8'h01, 32'h1801_FFFE);
    tx_b[5] = 8'h9A; tx_b[6] = 8'hBC;
    frame(56);
    chk({mem[12'hFFF], mem[12'hFFE]} == 16'h1234, "R4 below window ignored",
        {mem[12'hFFF], mem[12'hFFE]}, 64'h1234);
    chk(range_err, "R4 flag below window", 64'(range_err), 1);
    set_hdr(8'h02, 32'h0000_0104);
    frame(13 * 8);
    chk(!range_err, "R4 flag cleared by next frame", 64'(range_err), 0);
  endtask

  task automatic t_partial;
    set_hdr(8'h03, 32'h0000_0300);
    tx_b[5] = 8'h11; tx_b[6] = 8'h22; tx_b[7] = 8'h33; tx_b[8] = 8'h44;
    frame(40 + 28);
    chk({mem[12'h303], mem[12'h300]} == {init_val(12'h303), init_val(12'h300)},
        "R6 partial word dropped", {mem[12'h303], mem[12'h300]},
        {init_val(12'h303), init_val(12'h300)});
  endtask

  task automatic t_cap;
    logic ok;
    set_hdr(8'h05, 32'h0000_0400);
    for (int k = 0; k < 248; k++) tx_b[5 + k] = 8'(k) ^ 8'h33;
    tx_b[253] = 8'hEE;
    frame(254 * 8);
    ok = 1'b1;
    for (int i = 0; i < 240; i++) begin
      int src = (i / 8) * 8 + 7 - (i % 8);
      if (mem[12'h400 + i] != (8'(src) ^ 8'h33)) ok = 1'b0;
    end
    chk(ok, "R8 first 240 bytes stored", 64'(ok), 1);
    ok = 1'b1;
    for (int i = 240; i < 248; i++) if (mem[12'h400 + i] != init_val(12'h400 + i)) ok = 1'b0;
    chk(ok, "R8 word past limit dropped", mem[12'h4F0], init_val(12'h4F0));
  endtask

  task automatic t_badop;
    logic ok;
    set_hdr(8'h07, 32'h0000_0500);
    for (int k = 0; k < 9; k++) tx_b[5 + k] = 8'hA5;
    frame(14 * 8);
    set_hdr(8'h83, 32'h0000_0500);
    for (int k = 0; k < 9; k++) tx_b[5 + k] = 8'h5A;
    frame(14 * 8);
    ok = 1'b1;
    for (int i = 0; i < 8; i++) if (mem[12'h500 + i] != init_val(12'h500 + i)) ok = 1'b0;
    chk(ok, "R1 unknown commands ignored", mem[12'h500], init_val(12'h500));
  endtask

  logic done = 1'b0;
  initial begin
    cyc(5);
    rst_n = 1'b1;
    cyc(3);
    t_reset();
    t_wr32();
    t_rd32();
    t_align();
    t_burst();
    t_win16();
    t_outwin();
    t_partial();
    t_cap();
    t_badop();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule